// File: doc/BRIEF.md
# Execute Datapath Slice: Register Bank, ALU and Condition Codes

This block is the execution datapath slice of a small 16-bit processor. It holds eight general registers of 16 bits, an arithmetic/logic unit, a three-bit negative/zero/positive status register and the branch-condition test. An external sequencer supplies the twelve operand bits of the current instruction (everything below the opcode), an operation select, an operand-mode select and write controls. A separate bus carries values that come from outside the slice, such as loaded memory data or a return address.

The sequencer reads ALU results, both register read values and a branch-taken flag. The same adder computes register-plus-offset addresses for loads and stores. The status register always describes the last value written to the register bank, except for the return-address write of a subroutine call, which leaves it untouched.

Top module: `exec_slice`

## Requirements
- R1: While reset is low, and right after it, every register reads zero, `nzp` is 000 and `br_taken` is 0 even with mask 111.
- R2: `rd_a` shows register `op_field[8:6]` and `rd_b` shows register `op_field[2:0]`, both combinationally. A write lands at the clock edge into register `op_field[11:9]`. A read of that register in the same cycle returns the old value.
- R3: With `alu_op`=00 and `addr_mode`=0, `alu_y` is `rd_a` plus the second operand. The second operand is `rd_b` when `op_field[5]`=0, and `op_field[4:0]` sign-extended to 16 bits when `op_field[5]`=1. The sum wraps modulo 2^16.
- R4: With `alu_op`=01, `alu_y` is `rd_a` bitwise AND the second operand, chosen as in R3.
- R5: With `alu_op`=10, `alu_y` is the bitwise complement of `rd_a`.
- R6: With `alu_op`=11, `alu_y` equals `rd_a`.
- R7: With `addr_mode`=1, the second operand is `op_field[5:0]` sign-extended to 16 bits, whatever `op_field[5]` is. With `alu_op`=00 this gives base plus offset.
- R8: When `rf_we`=1, the value written is `wr_bus` if `rf_src`=1, otherwise `alu_y`.
- R9: A write with `link_wr`=0 sets `nzp` at the same edge. `nzp` becomes 100 if bit 15 of the written value is set, 010 if the value is zero, and 001 otherwise. `nzp` is never more than one-hot.
- R10: A write with `link_wr`=1 goes into register 7 regardless of `op_field[11:9]` and leaves `nzp` unchanged.
- R11: A cycle with `rf_we`=0 changes no register and leaves `nzp` unchanged.
- R12: `br_taken` is 1 exactly when `op_field[11:9]` AND `nzp` is nonzero, so mask 111 branches whenever any status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_field | input | 12 | Instruction bits below the opcode |
| alu_op | input | 2 | 00 add, 01 and, 10 complement, 11 pass first operand |
| addr_mode | input | 1 | Second operand is the 6-bit sign-extended offset |
| rf_we | input | 1 | Write the register bank at this edge |
| rf_src | input | 1 | Write data comes from wr_bus instead of the ALU |
| link_wr | input | 1 | Write targets register 7 and leaves the status register alone |
| wr_bus | input | 16 | External write data |
| alu_y | output | 16 | ALU result |
| rd_a | output | 16 | Read port A data |
| rd_b | output | 16 | Read port B data |
| br_taken | output | 1 | Branch condition met |
| nzp | output | 3 | Status register: bit 2 negative, bit 1 zero, bit 0 positive |

## Verification
The hardest case to reach is a status update that has to be suppressed. This happens when a return-address write would have changed `nzp` on its own terms, for example a negative value written while the status says zero. The directed stimulus first sets a known status, then issues link writes whose values disagree with it and checks that register 7 changed while `nzp` did not. A second hard case is a write and a read of the same register in one cycle. It is produced by choosing operand fields whose destination and first source match, in directed steps and also often in the randomized run, because the register indices are drawn from only eight values.

// File: rtl/exec_pkg.sv
package exec_pkg;

   typedef enum logic [1:0] {
      ALU_ADD  = 2'b00,
      ALU_AND  = 2'b01,
      ALU_NOT  = 2'b10,
      ALU_PASS = 2'b11
   } alu_op_e;

   localparam int unsigned NZP_W   = 3;
   localparam int unsigned NZP_NEG = 2;
   localparam int unsigned NZP_ZER = 1;
   localparam int unsigned NZP_POS = 0;

endpackage

// File: rtl/exec_regfile.sv
module exec_regfile #(
   parameter int unsigned DW   = 16,
   parameter int unsigned NREG = 8,
   localparam int unsigned AW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr_a,
   input  logic [AW-1:0] raddr_b,
   output logic [DW-1:0] rdata_a,
   output logic [DW-1:0] rdata_b
);

   logic [NREG-1:0][DW-1:0] bank;

   for (genvar gi = 0; gi < NREG; gi++) begin : g_ent
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (we && (waddr == AW'(gi)))
            q <= wdata;
      end
      assign bank[gi] = q;
   end

   // Reads see the stored value; a same-cycle write shows up after the edge.
   assign rdata_a = bank[raddr_a];
   assign rdata_b = bank[raddr_b];

endmodule

// File: rtl/exec_alu.sv
module exec_alu
   import exec_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  alu_op_e       op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] y
);

   always_comb begin
      unique case (op)
         ALU_ADD:  y = a + b;
         ALU_AND:  y = a & b;
         ALU_NOT:  y = ~a;
         ALU_PASS: y = a;
         default:  y = a;
      endcase
   end

endmodule

// File: rtl/exec_cond.sv
module exec_cond
   import exec_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic [DW-1:0]    wval,
   input  logic [NZP_W-1:0] mask,
   output logic [NZP_W-1:0] nzp_q,
   output logic             taken
);

   logic [NZP_W-1:0] nzp_d;

   always_comb begin
      nzp_d = '0;
      if (wval[DW-1])
         nzp_d[NZP_NEG] = 1'b1;
      else if (wval == '0)
         nzp_d[NZP_ZER] = 1'b1;
      else
         nzp_d[NZP_POS] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         nzp_q <= '0;
      else if (upd)
         nzp_q <= nzp_d;
   end

   assign taken = |(mask & nzp_q);

endmodule

// File: rtl/exec_slice.sv
module exec_slice
   import exec_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned NREGS  = 8,
   parameter int unsigned IMM_W  = 5,
   parameter int unsigned OFF_W  = 6,
   localparam int unsigned AW      = $clog2(NREGS),
   localparam int unsigned FIELD_W = OFF_W + 2 * AW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FIELD_W-1:0] op_field,
   input  logic [1:0]         alu_op,
   input  logic               addr_mode,
   input  logic               rf_we,
   input  logic               rf_src,
   input  logic               link_wr,
   input  logic [DATA_W-1:0]  wr_bus,
   output logic [DATA_W-1:0]  alu_y,
   output logic [DATA_W-1:0]  rd_a,
   output logic [DATA_W-1:0]  rd_b,
   output logic               br_taken,
   output logic [NZP_W-1:0]   nzp
);

   localparam int unsigned SR1_LO  = OFF_W;
   localparam int unsigned DST_LO  = OFF_W + AW;
   localparam int unsigned MODE_B  = IMM_W;
   localparam logic [AW-1:0] LINK_IDX = AW'(NREGS - 1);

   if (NREGS != (1 << AW)) begin : g_chk_pow2
      $error("NREGS must be a power of two");
   end
   if (AW != NZP_W) begin : g_chk_mask
      $error("destination field must match the status mask width");
   end
   if (OFF_W != IMM_W + 1) begin : g_chk_off
      $error("offset must be one bit wider than the immediate");
   end
   if (AW > IMM_W || OFF_W >= DATA_W) begin : g_chk_fit
      $error("field widths do not fit the data word");
   end

   logic [AW-1:0]     dst_idx, sr1_idx, sr2_idx, waddr;
   logic [DATA_W-1:0] imm_sx, off_sx, opnd_b, wdata;
   logic              cc_upd;

   assign dst_idx = op_field[DST_LO +: AW];
   assign sr1_idx = op_field[SR1_LO +: AW];
   assign sr2_idx = op_field[AW-1:0];

   assign imm_sx = {{(DATA_W-IMM_W){op_field[IMM_W-1]}}, op_field[IMM_W-1:0]};
   assign off_sx = {{(DATA_W-OFF_W){op_field[OFF_W-1]}}, op_field[OFF_W-1:0]};

   always_comb begin
      if (addr_mode)
         opnd_b = off_sx;
      else if (op_field[MODE_B])
         opnd_b = imm_sx;
      else
         opnd_b = rd_b;
   end

   assign waddr  = link_wr ? LINK_IDX : dst_idx;
   assign wdata  = rf_src ? wr_bus : alu_y;
   assign cc_upd = rf_we && !link_wr;

   exec_regfile #(
      .DW   (DATA_W),
      .NREG (NREGS)
   ) i_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (rf_we),
      .waddr   (waddr),
      .wdata   (wdata),
      .raddr_a (sr1_idx),
      .raddr_b (sr2_idx),
      .rdata_a (rd_a),
      .rdata_b (rd_b)
   );

   exec_alu #(
      .DW (DATA_W)
   ) i_alu (
      .op (alu_op_e'(alu_op)),
      .a  (rd_a),
      .b  (opnd_b),
      .y  (alu_y)
   );

   exec_cond #(
      .DW (DATA_W)
   ) i_cond (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (cc_upd),
      .wval  (wdata),
      .mask  (dst_idx),
      .nzp_q (nzp),
      .taken (br_taken)
   );

endmodule

// File: rtl/exec_slice_chk.sv
module exec_slice_chk #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned FIELD_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic [FIELD_W-1:0] op_field,
   input logic [1:0]         alu_op,
   input logic               addr_mode,
   input logic               rf_we,
   input logic               rf_src,
   input logic               link_wr,
   input logic [DATA_W-1:0]  wr_bus,
   input logic [DATA_W-1:0]  alu_y,
   input logic [DATA_W-1:0]  rd_a,
   input logic [DATA_W-1:0]  rd_b,
   input logic               br_taken,
   input logic [2:0]         nzp
);

   p_nzp_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(nzp));

   p_zero_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && !link_wr && rf_src && wr_bus == '0) |=> (nzp == 3'b010));

   p_neg_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && !link_wr && rf_src && wr_bus[DATA_W-1]) |=> (nzp == 3'b100));

   p_link_keeps_cc_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && link_wr) |=> $stable(nzp));

   p_idle_keeps_cc_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rf_we |=> $stable(nzp));

   p_uncond_branch_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (op_field[FIELD_W-1 -: 3] == 3'b111 && nzp != 3'b000) |-> br_taken);

   p_and_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_op == 2'b01 && !addr_mode && !op_field[5]) |-> (alu_y == (rd_a & rd_b)));

   p_not_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_op == 2'b10) |-> (alu_y == ~rd_a));

   p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_op == 2'b11) |-> (alu_y == rd_a));

endmodule

bind exec_slice exec_slice_chk #(
   .DATA_W  (DATA_W),
   .FIELD_W (FIELD_W)
) i_exec_slice_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_field  (op_field),
   .alu_op    (alu_op),
   .addr_mode (addr_mode),
   .rf_we     (rf_we),
   .rf_src    (rf_src),
   .link_wr   (link_wr),
   .wr_bus    (wr_bus),
   .alu_y     (alu_y),
   .rd_a      (rd_a),
   .rd_b      (rd_b),
   .br_taken  (br_taken),
   .nzp       (nzp)
);

// File: tb/test_exec_slice.sv
module test_exec_slice;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] op_field = '0;
   logic [1:0]  alu_op = '0;
   logic        addr_mode = 1'b0, rf_we = 1'b0, rf_src = 1'b0, link_wr = 1'b0;
   logic [15:0] wr_bus = '0;
   logic [15:0] alu_y, rd_a, rd_b;
   logic        br_taken;
   logic [2:0]  nzp;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   logic [15:0] m_rf [8];
   logic [2:0]  m_nzp;
   string       cc_tag = "R1";
   string       rd_tag = "R1";

   always #(CLK_P/2) clk = ~clk;

   exec_slice i_exec_slice (
      .clk(clk), .rst_n(rst_n), .op_field(op_field), .alu_op(alu_op),
      .addr_mode(addr_mode), .rf_we(rf_we), .rf_src(rf_src), .link_wr(link_wr),
      .wr_bus(wr_bus), .alu_y(alu_y), .rd_a(rd_a), .rd_b(rd_b),
      .br_taken(br_taken), .nzp(nzp)
   );

   task automatic cmp(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   // One cycle: drive after the falling edge, compare, then advance the model at the rising edge.
   task automatic step(input logic [11:0] f, input logic [1:0] op, input logic am,
                       input logic we, input logic src, input logic lnk, input logic [15:0] bus);
      logic [15:0] a, b, y, wv;
      logic [2:0]  d;
      string       ytag;
      @(negedge clk);
      op_field = f; alu_op = op; addr_mode = am; rf_we = we; rf_src = src; link_wr = lnk; wr_bus = bus;
      #1;
      a = m_rf[f[8:6]];
      if (am)        b = {{10{f[5]}}, f[5:0]};
      else if (f[5]) b = {{11{f[4]}}, f[4:0]};
      else           b = m_rf[f[2:0]];
      case (op)
         2'b00: y = a + b;
         2'b01: y = a & b;
         2'b10: y = ~a;
         default: y = a;
      endcase
      if (am) ytag = "R7";
      else case (op)
         2'b00: ytag = "R3";
         2'b01: ytag = "R4";
         2'b10: ytag = "R5";
         default: ytag = "R6";
      endcase
      cmp(ytag, "alu_y", alu_y, y);
      cmp(rd_tag, "rd_a", rd_a, m_rf[f[8:6]]);
      cmp(rd_tag, "rd_b", rd_b, m_rf[f[2:0]]);
      cmp(cc_tag, "nzp", {13'd0, nzp}, {13'd0, m_nzp});
      cmp("R12", "br_taken", {15'd0, br_taken}, {15'd0, |(f[11:9] & m_nzp)});
      @(posedge clk);
      if (we) begin
         wv = src ? bus : y;
         d  = lnk ? 3'd7 : f[11:9];
         m_rf[d] = wv;
         if (!lnk) m_nzp = wv[15] ? 3'b100 : (wv == 16'd0 ? 3'b010 : 3'b001);
         cc_tag = lnk ? "R10" : "R9";
         rd_tag = src ? "R8" : "R2";
      end else begin
         cc_tag = "R11";
         rd_tag = "R11";
      end
   endtask

   function automatic logic [11:0] fld(input int d, input int s1, input int md, input int lo5);
      return {3'(d), 3'(s1), 1'(md), 5'(lo5)};
   endfunction

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog run did not complete");
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) m_rf[i] = '0;
      m_nzp = '0;
      // R1: state while in reset
      repeat (2) @(negedge clk);
      op_field = fld(7, 1, 0, 2);
      #1;
      cmp("R1", "rd_a in reset", rd_a, 16'h0);
      cmp("R1", "rd_b in reset", rd_b, 16'h0);
      cmp("R1", "nzp in reset", {13'd0, nzp}, 16'h0);
      cmp("R1", "br_taken in reset", {15'd0, br_taken}, 16'h0);
      @(negedge clk); rst_n = 1'b1;
      step(fld(7, 3, 0, 4), 2'b00, 0, 0, 0, 0, 16'h0);

      // R8: load registers from the bus; R9 status per value
      step(fld(1, 0, 0, 0), 2'b00, 0, 1, 1, 0, 16'h1234);
      step(fld(2, 1, 0, 0), 2'b00, 0, 1, 1, 0, 16'h8000);
      step(fld(3, 2, 0, 0), 2'b00, 0, 1, 1, 0, 16'h0000);
      step(fld(4, 3, 0, 0), 2'b00, 0, 1, 1, 0, 16'h00F0);
      step(fld(5, 4, 0, 0), 2'b00, 0, 1, 1, 0, 16'hFFFF);
      // R3 register and immediate add, ALU result written back
      step(fld(6, 1, 0, 4), 2'b00, 0, 1, 0, 0, 16'h0);
      step(fld(6, 6, 1, 5'b10000), 2'b00, 0, 1, 0, 0, 16'h0);
      step(fld(0, 5, 1, 5'b00001), 2'b00, 0, 1, 0, 0, 16'h0);   // wraps to zero
      // R4 register and immediate and
      step(fld(0, 1, 0, 5), 2'b01, 0, 1, 0, 0, 16'h0);
      step(fld(0, 1, 1, 5'b11100), 2'b01, 0, 1, 0, 0, 16'h0);
      // R5 complement, R6 pass
      step(fld(3, 3, 0, 0), 2'b10, 0, 1, 0, 0, 16'h0);
      step(fld(3, 2, 1, 3), 2'b11, 0, 0, 0, 0, 16'h0);
      // R7 address mode, negative and positive offsets, mode bit ignored
      step({3'd0, 3'd4, 6'b100000}, 2'b00, 1, 0, 0, 0, 16'h0);
      step({3'd0, 3'd4, 6'b011111}, 2'b00, 1, 0, 0, 0, 16'h0);
      // R2 same-cycle write and read of one register
      step(fld(4, 4, 1, 1), 2'b00, 0, 1, 0, 0, 16'h0);
      step(fld(4, 4, 1, 1), 2'b00, 0, 0, 0, 0, 16'h0);
      // R10 link write: negative and zero values while status differs
      step(fld(1, 1, 0, 0), 2'b00, 0, 1, 1, 0, 16'h0001);
      step(fld(2, 7, 0, 0), 2'b00, 0, 1, 1, 1, 16'h9000);
      step(fld(2, 7, 0, 0), 2'b00, 0, 1, 1, 1, 16'h0000);
      step(fld(2, 7, 0, 0), 2'b00, 0, 0, 0, 0, 16'h0);
      // R11 idle with busy bus
      step(fld(1, 1, 0, 0), 2'b00, 0, 0, 1, 0, 16'hAAAA);
      step(fld(1, 1, 0, 0), 2'b00, 0, 0, 1, 0, 16'h0);
      // R12 every mask against each status
      for (int s = 0; s < 3; s++) begin
         step(fld(0, 0, 0, 0), 2'b00, 0, 1, 1, 0, (s == 0) ? 16'h8001 : (s == 1) ? 16'h0 : 16'h0005);
         for (int m = 0; m < 8; m++) step(fld(m, 0, 0, 0), 2'b00, 0, 0, 0, 0, 16'h0);
      end
      // Randomized run against the model
      for (int k = 0; k < 1500; k++) begin
         logic [31:0] r;
         r = $urandom;
         step(r[11:0], r[13:12], (r[17:14] == 0), r[18] | r[19], r[20], (r[23:21] == 0), r[15:0] ^ 16'(r[31:16]));
      end
      done = 1;
      summary();
      $finish;
   end

endmodule